// File: doc/BRIEF.md
# Locked region configuration register file

This block holds the configuration of a set of protected memory regions (four by default) and serves it through a simple single-cycle register port. Each region has a control word (enable, two set-once locks, a 2-bit mode and a 16-bit version), a start bound, an end bound and a 64-bit nonce. The block exports these values to the address-decode and cipher blocks. The key storage lives elsewhere: its 8-bit checksum arrives on an input and is shown in the control word. The block sends back a one-cycle wipe pulse whenever a region's mode really changes.

Each region's locks are tracked by a small state machine with three states. `LK_OPEN` means nothing is locked. `LK_KEY` means only the key lock is set. `LK_ALL` means the configuration lock is set, which also implies the key lock. The transitions are:

- Open-to-key: a control write with the key-lock bit set and the config-lock bit clear.
- Open-to-all or key-to-all: a control write with the config-lock bit set.
- All-hold: `LK_ALL` is left only by reset.

An illegal encoding falls to `LK_ALL`.

A global privilege bit filters every register access except reads of the privilege register itself. Bounds are stored only as the address bits that matter. On readback they are padded: a start bound reads with zeros in both ignored bit ranges, and an end bound reads with ones in its low bits.

Top module: `prot_region_cfg`

## Requirements
- R1: After reset every register reads zero except the key checksum field, and every exported enable, mode, version, bound, nonce, lock and wipe output is zero.
- R2: The region control word has the following layout. Writes update the enable, mode and version fields; bits 3 and 7:6 read zero.

  | Bits | Field |
  |------|-------|
  | 0 | enable |
  | 1 | config lock |
  | 2 | key lock |
  | 5:4 | mode |
  | 15:8 | key checksum, from `key_crc_i`, read-only |
  | 31:16 | version |

- R3: The two lock bits can only be set by writing a 1. Writing 0 never clears them; only reset does.
- R4: Writing 1 to the config-lock bit also sets the key lock in the same cycle.
- R5: While a region's config lock is set, writes to its start bound, end bound and nonce words are ignored. Control-word writes then change only the enable bit.
- R6: A start bound reads back as the written value with bits 11:0 and 31:28 forced to zero.
- R7: An end bound reads back as the written value with bits 11:0 forced to one and bits 31:28 forced to zero.
- R8: While the privilege bit is 1, reads with `req_priv` low return zero and writes with `req_priv` low are ignored, for every register except the privilege register.
- R9: The privilege bit sits at bit 0 of byte offset 0x80 (NUM_REGIONS*32). Only writes with `req_priv` high change it. Any access may read it.
- R10: `key_wipe_o[r]` is high for exactly the cycle after an accepted control write to region r whose mode field differs from the stored mode. A write that keeps the mode, or one made while the config lock is set, gives no pulse.
- R11: Region r occupies byte offsets r*0x20 onward, with its words in this order: control, start, end, nonce bits 31:0, nonce bits 63:32. Reads of any other offset return zero and writes to them have no effect.
- R12: The exported bounds are address bits 27:12 of the stored start and end values. The exported nonce, version, mode, enable and lock outputs follow the stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | Access is privileged |
| req_addr | input | RADDR_W (8) | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid in the cycle of a read request |
| key_crc_i | input | NUM_REGIONS*8 | Per-region key checksum from the key store |
| region_en_o | output | NUM_REGIONS | Region enable |
| region_mode_o | output | NUM_REGIONS*2 | Region mode |
| region_version_o | output | NUM_REGIONS*16 | Region firmware version |
| region_start_o | output | NUM_REGIONS*16 | Start bound, address bits 27:12 |
| region_end_o | output | NUM_REGIONS*16 | End bound, address bits 27:12 |
| region_nonce_o | output | NUM_REGIONS*64 | Region nonce |
| key_lock_o | output | NUM_REGIONS | Key lock state |
| cfg_lock_o | output | NUM_REGIONS | Config lock state |
| key_wipe_o | output | NUM_REGIONS | One-cycle pulse that zeroes the region key |

## Verification
The interesting collision is a single control write that both sets the config lock and changes the mode and version. The lock state machine samples the unlocked state at that edge, so the new mode, the new version and the wipe pulse must all land, and only later writes are frozen. The bench provokes this with a directed write on one region and with random control writes that carry the lock bit with a small probability. Each outcome is judged by comparing the wipe vector, the readback and the exported values against a bench model that applies the lock only after the write completes.

// File: rtl/prot_region_pkg.sv
package prot_region_pkg;

    localparam int WORD_W     = 32;
    localparam int MODE_W     = 2;
    localparam int VER_W      = 16;
    localparam int CRC_W      = 8;
    localparam int LOW_IGN    = 12;
    localparam int HIGH_IGN   = 4;
    localparam int BOUND_W    = WORD_W - LOW_IGN - HIGH_IGN;
    localparam int NONCE_W    = 2 * WORD_W;
    localparam int SLOT_BYTES = 32;
    localparam int SLOT_SH    = $clog2(SLOT_BYTES);
    localparam int FIELD_LSB  = 2;
    localparam int FIELD_W    = SLOT_SH - FIELD_LSB;

    // control word bit positions
    localparam int EN_B     = 0;
    localparam int CLK_B    = 1;
    localparam int KLK_B    = 2;
    localparam int MODE_LSB = 4;
    localparam int CRC_LSB  = 8;
    localparam int VER_LSB  = 16;

    typedef enum logic [FIELD_W-1:0] {
        FLD_CFG      = 3'd0,
        FLD_START    = 3'd1,
        FLD_END      = 3'd2,
        FLD_NONCE_LO = 3'd3,
        FLD_NONCE_HI = 3'd4
    } field_t;

    typedef enum logic [1:0] {
        LK_OPEN = 2'd0,
        LK_KEY  = 2'd1,
        LK_ALL  = 2'd2
    } lock_state_t;

endpackage

// File: rtl/prot_region_lock_fsm.sv
module prot_region_lock_fsm
    import prot_region_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic set_key,
    input  logic set_cfg,
    output logic key_locked,
    output logic cfg_locked
);

    lock_state_t st_q, st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LK_OPEN;
        else        st_q <= st_d;
    end

    // next state: locks only ever move towards LK_ALL
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LK_OPEN: begin
                if (cfg_wr && set_cfg)      st_d = LK_ALL;
                else if (cfg_wr && set_key) st_d = LK_KEY;
            end
            LK_KEY: begin
                if (cfg_wr && set_cfg) st_d = LK_ALL;
            end
            LK_ALL:  st_d = LK_ALL;
            default: st_d = LK_ALL;
        endcase
    end

    // outputs
    always_comb begin
        key_locked = 1'b1;
        cfg_locked = 1'b1;
        unique case (st_q)
            LK_OPEN: begin key_locked = 1'b0; cfg_locked = 1'b0; end
            LK_KEY:  begin key_locked = 1'b1; cfg_locked = 1'b0; end
            LK_ALL:  begin key_locked = 1'b1; cfg_locked = 1'b1; end
            default: begin key_locked = 1'b1; cfg_locked = 1'b1; end
        endcase
    end

endmodule

// File: rtl/prot_region_slot.sv
module prot_region_slot
    import prot_region_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  field_t             field,
    input  logic [WORD_W-1:0]  wdata,
    input  logic [CRC_W-1:0]   key_crc,
    output logic [WORD_W-1:0]  rdata,
    output logic               en,
    output logic [MODE_W-1:0]  mode,
    output logic [VER_W-1:0]   version,
    output logic [BOUND_W-1:0] bound_lo,
    output logic [BOUND_W-1:0] bound_hi,
    output logic [NONCE_W-1:0] nonce,
    output logic               key_locked,
    output logic               cfg_locked,
    output logic               key_wipe
);

    logic               en_q;
    logic [MODE_W-1:0]  mode_q;
    logic [VER_W-1:0]   ver_q;
    logic [BOUND_W-1:0] start_q, end_q;
    logic [WORD_W-1:0]  nlo_q, nhi_q;
    logic               wipe_q;
    logic               cfg_wr;
    logic [MODE_W-1:0]  wmode;

    assign cfg_wr = wr_en && (field == FLD_CFG);
    assign wmode  = wdata[MODE_LSB +: MODE_W];

    prot_region_lock_fsm lock_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .set_key    (wdata[KLK_B]),
        .set_cfg    (wdata[CLK_B]),
        .key_locked (key_locked),
        .cfg_locked (cfg_locked)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            mode_q  <= '0;
            ver_q   <= '0;
            start_q <= '0;
            end_q   <= '0;
            nlo_q   <= '0;
            nhi_q   <= '0;
            wipe_q  <= 1'b0;
        end else begin
            wipe_q <= cfg_wr && !cfg_locked && (wmode != mode_q);
            if (cfg_wr) begin
                en_q <= wdata[EN_B];
                if (!cfg_locked) begin
                    mode_q <= wmode;
                    ver_q  <= wdata[VER_LSB +: VER_W];
                end
            end
            if (wr_en && !cfg_locked) begin
                if (field == FLD_START)    start_q <= wdata[LOW_IGN +: BOUND_W];
                if (field == FLD_END)      end_q   <= wdata[LOW_IGN +: BOUND_W];
                if (field == FLD_NONCE_LO) nlo_q   <= wdata;
                if (field == FLD_NONCE_HI) nhi_q   <= wdata;
            end
        end
    end

    // readback shaping
    always_comb begin
        rdata = '0;
        case (field)
            FLD_CFG: begin
                rdata[EN_B]                = en_q;
                rdata[CLK_B]               = cfg_locked;
                rdata[KLK_B]               = key_locked;
                rdata[MODE_LSB +: MODE_W]  = mode_q;
                rdata[CRC_LSB +: CRC_W]    = key_crc;
                rdata[VER_LSB +: VER_W]    = ver_q;
            end
            FLD_START:    rdata = {{HIGH_IGN{1'b0}}, start_q, {LOW_IGN{1'b0}}};
            FLD_END:      rdata = {{HIGH_IGN{1'b0}}, end_q, {LOW_IGN{1'b1}}};
            FLD_NONCE_LO: rdata = nlo_q;
            FLD_NONCE_HI: rdata = nhi_q;
            default:      rdata = '0;
        endcase
    end

    assign en       = en_q;
    assign mode     = mode_q;
    assign version  = ver_q;
    assign bound_lo = start_q;
    assign bound_hi = end_q;
    assign nonce    = {nhi_q, nlo_q};
    assign key_wipe = wipe_q;

endmodule

// File: rtl/prot_region_cfg.sv
module prot_region_cfg
    import prot_region_pkg::*;
#(
    parameter  int NUM_REGIONS = 4,
    localparam int PRIV_OFS    = NUM_REGIONS * SLOT_BYTES,
    localparam int RADDR_W     = $clog2(PRIV_OFS + 4),
    localparam int IDX_W       = RADDR_W - SLOT_SH
)(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic                           req_priv,
    input  logic [RADDR_W-1:0]             req_addr,
    input  logic [WORD_W-1:0]              req_wdata,
    output logic [WORD_W-1:0]              rsp_rdata,
    input  logic [NUM_REGIONS*CRC_W-1:0]   key_crc_i,
    output logic [NUM_REGIONS-1:0]         region_en_o,
    output logic [NUM_REGIONS*MODE_W-1:0]  region_mode_o,
    output logic [NUM_REGIONS*VER_W-1:0]   region_version_o,
    output logic [NUM_REGIONS*BOUND_W-1:0] region_start_o,
    output logic [NUM_REGIONS*BOUND_W-1:0] region_end_o,
    output logic [NUM_REGIONS*NONCE_W-1:0] region_nonce_o,
    output logic [NUM_REGIONS-1:0]         key_lock_o,
    output logic [NUM_REGIONS-1:0]         cfg_lock_o,
    output logic [NUM_REGIONS-1:0]         key_wipe_o
);

    logic              priv_q;
    logic              is_priv_reg;
    logic              granted;
    logic [IDX_W-1:0]  slot_idx;
    field_t            field;
    logic [FIELD_LSB-1:0] unused_addr_lsb;
    logic [WORD_W-1:0] slot_rd [NUM_REGIONS];

    assign is_priv_reg     = (req_addr == RADDR_W'(PRIV_OFS));
    assign granted         = !priv_q || req_priv;
    assign slot_idx        = req_addr[RADDR_W-1:SLOT_SH];
    assign field           = field_t'(req_addr[SLOT_SH-1:FIELD_LSB]);
    assign unused_addr_lsb = req_addr[FIELD_LSB-1:0];

    // privilege bit: privileged writes only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            priv_q <= 1'b0;
        else if (req_valid && req_write && req_priv && is_priv_reg)
            priv_q <= req_wdata[0];
    end

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_slot
        logic wr_sel;
        assign wr_sel = req_valid && req_write && granted && !is_priv_reg
                        && (slot_idx == IDX_W'(g));

        prot_region_slot slot_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_sel),
            .field      (field),
            .wdata      (req_wdata),
            .key_crc    (key_crc_i[g*CRC_W +: CRC_W]),
            .rdata      (slot_rd[g]),
            .en         (region_en_o[g]),
            .mode       (region_mode_o[g*MODE_W +: MODE_W]),
            .version    (region_version_o[g*VER_W +: VER_W]),
            .bound_lo   (region_start_o[g*BOUND_W +: BOUND_W]),
            .bound_hi   (region_end_o[g*BOUND_W +: BOUND_W]),
            .nonce      (region_nonce_o[g*NONCE_W +: NONCE_W]),
            .key_locked (key_lock_o[g]),
            .cfg_locked (cfg_lock_o[g]),
            .key_wipe   (key_wipe_o[g])
        );
    end

    // read path: single cycle, filtered by privilege
    always_comb begin
        rsp_rdata = '0;
        if (req_valid && !req_write) begin
            if (is_priv_reg) begin
                rsp_rdata[0] = priv_q;
            end else if (granted) begin
                for (int i = 0; i < NUM_REGIONS; i++) begin
                    if (slot_idx == IDX_W'(i)) rsp_rdata = slot_rd[i];
                end
            end
        end
    end

endmodule

// File: rtl/prot_region_cfg_chk.sv
module prot_region_cfg_chk
    import prot_region_pkg::*;
#(
    parameter  int NUM_REGIONS = 4,
    localparam int PRIV_OFS    = NUM_REGIONS * SLOT_BYTES,
    localparam int RADDR_W     = $clog2(PRIV_OFS + 4)
)(
    input logic                           clk,
    input logic                           rst_n,
    input logic                           req_valid,
    input logic                           req_write,
    input logic                           req_priv,
    input logic                           is_priv_reg,
    input logic                           priv_q,
    input logic [WORD_W-1:0]              rsp_rdata,
    input logic [NUM_REGIONS*MODE_W-1:0]  region_mode_o,
    input logic [NUM_REGIONS*VER_W-1:0]   region_version_o,
    input logic [NUM_REGIONS*BOUND_W-1:0] region_start_o,
    input logic [NUM_REGIONS*BOUND_W-1:0] region_end_o,
    input logic [NUM_REGIONS*NONCE_W-1:0] region_nonce_o,
    input logic [NUM_REGIONS-1:0]         key_lock_o,
    input logic [NUM_REGIONS-1:0]         cfg_lock_o,
    input logic [NUM_REGIONS-1:0]         key_wipe_o
);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
        a_r3_cfg_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_lock_o[g] |=> cfg_lock_o[g]);

        a_r3_key_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            key_lock_o[g] |=> key_lock_o[g]);

        a_r4_cfg_implies_key: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_lock_o[g] |-> key_lock_o[g]);

        a_r5_frozen_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_lock_o[g] |=> ($stable(region_start_o[g*BOUND_W +: BOUND_W])
                            && $stable(region_end_o[g*BOUND_W +: BOUND_W])
                            && $stable(region_nonce_o[g*NONCE_W +: NONCE_W])
                            && $stable(region_mode_o[g*MODE_W +: MODE_W])
                            && $stable(region_version_o[g*VER_W +: VER_W])));

        a_r10_wipe_only_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
            key_wipe_o[g] |-> !$past(cfg_lock_o[g]));

        a_r10_wipe_on_mode_move: assert property (@(posedge clk) disable iff (!rst_n)
            key_wipe_o[g] |-> (region_mode_o[g*MODE_W +: MODE_W]
                               != $past(region_mode_o[g*MODE_W +: MODE_W])));
    end

    a_r8_unpriv_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_priv && priv_q && !is_priv_reg) |-> (rsp_rdata == '0));

    a_r9_priv_bit_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(priv_q) |-> $past(req_valid && req_write && req_priv && is_priv_reg));

endmodule

bind prot_region_cfg prot_region_cfg_chk #(.NUM_REGIONS(NUM_REGIONS)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_write        (req_write),
    .req_priv         (req_priv),
    .is_priv_reg      (is_priv_reg),
    .priv_q           (priv_q),
    .rsp_rdata        (rsp_rdata),
    .region_mode_o    (region_mode_o),
    .region_version_o (region_version_o),
    .region_start_o   (region_start_o),
    .region_end_o     (region_end_o),
    .region_nonce_o   (region_nonce_o),
    .key_lock_o       (key_lock_o),
    .cfg_lock_o       (cfg_lock_o),
    .key_wipe_o       (key_wipe_o)
);

// File: tb/prot_region_cfg_tb_top.sv
module prot_region_cfg_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic         req_priv = 1'b0;
    logic [7:0]   req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [31:0]  rsp_rdata;
    logic [31:0]  key_crc_i = 32'hD4_93_5A_27;
    logic [3:0]   region_en_o;
    logic [7:0]   region_mode_o;
    logic [63:0]  region_version_o;
    logic [63:0]  region_start_o;
    logic [63:0]  region_end_o;
    logic [255:0] region_nonce_o;
    logic [3:0]   key_lock_o;
    logic [3:0]   cfg_lock_o;
    logic [3:0]   key_wipe_o;

    prot_region_cfg #(.NUM_REGIONS(NREG)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_priv(req_priv), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .key_crc_i(key_crc_i), .region_en_o(region_en_o),
        .region_mode_o(region_mode_o), .region_version_o(region_version_o),
        .region_start_o(region_start_o), .region_end_o(region_end_o),
        .region_nonce_o(region_nonce_o), .key_lock_o(key_lock_o),
        .cfg_lock_o(cfg_lock_o), .key_wipe_o(key_wipe_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model of the register state
    bit        m_priv;
    bit        m_en [NREG];
    bit        m_cl [NREG];
    bit        m_kl [NREG];
    bit [1:0]  m_mode [NREG];
    bit [15:0] m_ver [NREG];
    bit [31:0] m_start [NREG];
    bit [31:0] m_end [NREG];
    bit [31:0] m_nlo [NREG];
    bit [31:0] m_nhi [NREG];

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        m_priv = 1'b0;
        for (int r = 0; r < NREG; r++) begin
            m_en[r] = 0; m_cl[r] = 0; m_kl[r] = 0; m_mode[r] = 0; m_ver[r] = 0;
            m_start[r] = 0; m_end[r] = 0; m_nlo[r] = 0; m_nhi[r] = 0;
        end
    endfunction

    // returns the expected wipe vector for the cycle after the write
    function automatic logic [3:0] model_write(input logic [7:0] a, input logic [31:0] d, input bit p);
        logic [3:0] w = 4'b0;
        int r, f;
        if (a == 8'h80) begin
            if (p) m_priv = d[0];
            return w;
        end
        if (m_priv && !p) return w;
        r = int'(a[7:5]);
        f = int'(a[4:2]);
        if (r >= NREG) return w;
        case (f)
            0: begin
                if (m_cl[r]) begin
                    m_en[r] = d[0];
                end else begin
                    if (d[5:4] != m_mode[r]) w[r] = 1'b1;
                    m_en[r] = d[0]; m_mode[r] = d[5:4]; m_ver[r] = d[31:16];
                    if (d[1]) begin m_cl[r] = 1; m_kl[r] = 1; end
                    if (d[2]) m_kl[r] = 1;
                end
            end
            1: if (!m_cl[r]) m_start[r] = d;
            2: if (!m_cl[r]) m_end[r] = d;
            3: if (!m_cl[r]) m_nlo[r] = d;
            4: if (!m_cl[r]) m_nhi[r] = d;
            default: ;
        endcase
        return w;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a, input bit p);
        int r, f;
        if (a == 8'h80) return {31'b0, m_priv};
        if (m_priv && !p) return 32'h0;
        r = int'(a[7:5]);
        f = int'(a[4:2]);
        if (r >= NREG) return 32'h0;
        case (f)
            0: return {m_ver[r], key_crc_i[r*8 +: 8], 2'b00, m_mode[r], 1'b0, m_kl[r], m_cl[r], m_en[r]};
            1: return m_start[r] & 32'h0FFF_F000;
            2: return (m_end[r] & 32'h0FFF_F000) | 32'h0000_0FFF;
            3: return m_nlo[r];
            4: return m_nhi[r];
            default: return 32'h0;
        endcase
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input bit p, input string tag);
        logic [3:0] ew;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_priv = p; req_addr = a; req_wdata = d;
        ew = model_write(a, d, p);
        @(posedge clk);
        #1;
        req_valid = 1'b0; req_write = 1'b0;
        check32({tag, " wipe pulse R10"}, {28'b0, key_wipe_o}, {28'b0, ew});
    endtask

    task automatic do_read(input logic [7:0] a, input bit p, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_priv = p; req_addr = a;
        #1;
        check32(tag, rsp_rdata, exp_read(a, p));
        req_valid = 1'b0;
    endtask

    task automatic check_exports(input string tag);
        @(negedge clk);
        for (int r = 0; r < NREG; r++) begin
            check32({tag, " controls"},
                {24'b0, region_en_o[r], cfg_lock_o[r], key_lock_o[r], 3'b0, region_mode_o[r*2 +: 2]},
                {24'b0, m_en[r], m_cl[r], m_kl[r], 3'b0, m_mode[r]});
            check32({tag, " version"}, {16'b0, region_version_o[r*16 +: 16]}, {16'b0, m_ver[r]});
            check32({tag, " start bound"}, {16'b0, region_start_o[r*16 +: 16]}, {16'b0, m_start[r][27:12]});
            check32({tag, " end bound"}, {16'b0, region_end_o[r*16 +: 16]}, {16'b0, m_end[r][27:12]});
            check32({tag, " nonce lo"}, region_nonce_o[r*64 +: 32], m_nlo[r]);
            check32({tag, " nonce hi"}, region_nonce_o[r*64+32 +: 32], m_nhi[r]);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    function automatic string tag_of(input logic [7:0] a, input bit p);
        if (a == 8'h80) return "R9 priv read";
        if (m_priv && !p) return "R8 filtered read";
        if (a[7:5] >= 3'(NREG)) return "R11 unmapped";
        case (a[4:2])
            3'd0: return "R2 cfg read";
            3'd1: return "R6 start read";
            3'd2: return "R7 end read";
            3'd3, 3'd4: return "R11 nonce read";
            default: return "R11 unmapped";
        endcase
    endfunction

    function automatic logic [7:0] rand_addr();
        int k = int'($urandom % 16);
        if (k == 0) return 8'h80;
        if (k == 1) return 8'($urandom) & 8'hFC;
        return {3'($urandom % NREG), 3'($urandom % 6), 2'b00};
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0_FFEE));
        model_reset();
        apply_reset();

        // R1: reset state
        for (int r = 0; r < NREG; r++)
            for (int f = 0; f < 5; f++)
                do_read({3'(r), 3'(f), 2'b00}, 1'b1, "R1 reset readback");
        do_read(8'h80, 1'b0, "R1 reset priv");
        check_exports("R1 reset exports");
        check32("R1 reset wipe", {28'b0, key_wipe_o}, 32'h0);

        // R2 / R10: layout, mode change pulses, same mode does not
        do_write(8'h00, 32'hABCD_0031, 1'b1, "R2 cfg write");
        do_read (8'h00, 1'b1, "R2 cfg layout");
        do_write(8'h00, 32'hABCD_0030, 1'b1, "R10 same mode");
        // R3: key lock set-only
        do_write(8'h00, 32'h0000_0034, 1'b1, "R3 set key lock");
        do_write(8'h00, 32'h0000_0030, 1'b1, "R3 try clear");
        do_read (8'h00, 1'b1, "R3 key lock sticky");
        // R6 / R7: readback shaping, key lock alone leaves bounds writable
        do_write(8'h04, 32'h1234_5678, 1'b1, "R6 start write");
        do_read (8'h04, 1'b1, "R6 start shape");
        do_write(8'h08, 32'h0000_0000, 1'b1, "R7 end write");
        do_read (8'h08, 1'b1, "R7 end shape zero");
        do_write(8'h08, 32'hFFFF_FFFF, 1'b1, "R7 end write");
        do_read (8'h08, 1'b1, "R7 end shape ones");
        // R4 / R5: config lock forces key lock, freezes region 1
        do_write(8'h2C, 32'h1111_2222, 1'b1, "R5 nonce before lock");
        do_write(8'h20, 32'h0000_0002, 1'b1, "R4 set cfg lock");
        do_read (8'h20, 1'b1, "R4 key lock forced");
        do_write(8'h24, 32'hFFFF_FFFF, 1'b1, "R5 start locked");
        do_read (8'h24, 1'b1, "R5 start unchanged");
        do_write(8'h2C, 32'hDEAD_BEEF, 1'b1, "R5 nonce locked");
        do_read (8'h2C, 1'b1, "R5 nonce unchanged");
        do_write(8'h20, 32'h5555_0021, 1'b1, "R5 cfg locked write");
        do_read (8'h20, 1'b1, "R5 only enable moved");
        // lock and mode change in the same write
        do_write(8'h40, 32'h7777_0012, 1'b1, "R10 lock with mode");
        do_read (8'h40, 1'b1, "R10 lock with mode");
        // R8 / R9: privilege filter
        do_write(8'h80, 32'h0000_0001, 1'b1, "R9 set priv");
        do_read (8'h00, 1'b0, "R8 unpriv read zero");
        do_write(8'h64, 32'hFFFF_FFFF, 1'b0, "R8 unpriv write");
        do_read (8'h64, 1'b1, "R8 unpriv write ignored");
        do_read (8'h00, 1'b1, "R8 priv read");
        do_write(8'h80, 32'h0000_0000, 1'b0, "R9 unpriv priv write");
        do_read (8'h80, 1'b0, "R9 priv readable");
        do_write(8'h80, 32'h0000_0000, 1'b1, "R9 clear priv");
        do_read (8'h80, 1'b0, "R9 priv cleared");
        // R11: unmapped offsets
        do_write(8'h14, 32'hFFFF_FFFF, 1'b1, "R11 unmapped write");
        do_read (8'h14, 1'b1, "R11 unmapped slot word");
        do_read (8'h84, 1'b1, "R11 past priv");
        do_read (8'hE0, 1'b1, "R11 beyond regions");
        check_exports("R12 exports directed");

        // R3: only reset clears locks
        apply_reset();
        do_read(8'h20, 1'b1, "R3 lock cleared by reset");
        check_exports("R1 exports after reset");

        // random phase
        for (int it = 0; it < 600; it++) begin
            logic [7:0]  a = rand_addr();
            bit          p = ($urandom % 4) != 0;
            logic [31:0] d = $urandom;
            if (($urandom % 10) != 0) d[1] = 1'b0;
            if (($urandom % 4) != 0)  d[2] = 1'b0;
            if ($urandom % 2) do_write(a, d, p, "R5 random write");
            else              do_read(a, p, tag_of(a, p));
            if (it % 50 == 49) check_exports("R12 exports random");
            if (it == 299) apply_reset();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule